// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters that share one clock and sit behind a byte-wide register interface. Ports 0, 1 and 2 reach the count registers of channels 0, 1 and 2. Port 3 takes command bytes. A command byte either sets up a channel, freezes a channel's count for a clean read, or captures a status byte for one or more channels. Each channel drives one output pin. The pin's waveform depends on which of six counting modes is selected: a one-shot interrupt on terminal count, a gate-triggered one-shot, a rate generator, a square wave, a software strobe or a gate-triggered strobe.

Channels 0 and 1 always have their gate enabled. Channel 2 takes the external gate input `gate2`. The gate pauses the level-sensitive modes and starts the edge-triggered modes. Each channel counts in binary or in four-digit BCD. Software can reach the count as a low byte only, a high byte only, or a low byte followed by a high byte.

Top module: `triple_interval_timer`

## Requirements
- R1: After reset every channel is in mode 0 with binary counting and two-byte access, all outputs are low and no count is loaded, so the status byte of each channel reads 0x30.
- R2: A command byte whose bits 5-4 are nonzero programs the channel selected by bits 7-6 (0, 1 or 2). Bits 5-4 give the access mode, bits 3-1 give the counting mode (codes 110 and 111 act as 010 and 011), and bit 0 selects BCD. The command stops the channel, clears its byte pointers and pending latches, and sets its output low for mode 0 and high for every other mode.
- R3: A count takes effect only once its final byte is written (the second byte in two-byte access). The first count step happens on the clock after that write. Until then the output holds and the status byte shows no count loaded (bit 6 = 0).
- R4: Mode 0: the output stays low and goes high N clocks after the count N is loaded. The count then stays at zero.
- R5: Mode 1: a rising edge on channel 2's gate reloads N and drives the output low. The countdown then runs to zero even if the gate falls, and the output goes high N clocks after the trigger edge.
- R6: Mode 2: the output is high and goes low for one clock when the count reaches 1. The count then reloads, so the output has period N.
- R7: Mode 3: the output is a square wave of period N, high for (N+1)/2 clocks and low for N/2 clocks (integer division), starting high. The count steps by two, and every value read back is even.
- R8: Mode 4: the output stays high and pulses low for exactly one clock, N clocks after loading. The count does not reload.
- R9: Mode 5: a rising edge on channel 2's gate starts the countdown. The output pulses low for one clock N clocks after the edge.
- R10: When channel 2's gate is low, the count is frozen in modes 0, 2, 3 and 4. In modes 2 and 3 the output is also held high. Channels 0 and 1 always count.
- R11: A command byte with bits 5-4 = 00 and bits 7-6 = channel freezes that channel's count in a latch. Later latch commands for that channel are ignored until the latched value has been fully read out in the current access mode.
- R12: Command 1110 captures a status byte for each channel whose bit is set (bit 1 = channel 0, bit 2 = channel 1, bit 3 = channel 2). The byte is laid out as: bit 7 output, bit 6 count loaded, bits 5-4 access mode, bits 3-1 mode, bit 0 BCD. The next read of that channel returns it ahead of any count. Further status commands for the channel are ignored until that read.
- R13: With bit 0 of the mode command set, the count runs in BCD: the counter steps from 0x0100 to 0x0099, and a count of 0x0012 times out after twelve clocks.
- R14: In low-byte-only access (bits 5-4 = 01) one written byte becomes the count with the high byte zero. In high-byte-only access (10) one written byte becomes the high byte with the low byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; every edge is one count step |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select qualifying rd and wr |
| wr | input | 1 | Single-cycle write strobe |
| rd | input | 1 | Single-cycle read strobe; advances read pointers and clears latches |
| addr | input | 2 | Port select: 0 to 2 count ports, 3 command port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from addr |
| gate2 | input | 1 | Gate of channel 2, synchronous to clk |
| tmr_out | output | 3 | Output pins of channels 2..0 |

## Verification
The assertions assume that a read or write is a one-cycle strobe with cs high, that rd and wr are never both high, and that gate2 changes only between clock edges. The bench drives every access through tasks that change the inputs at the falling clock edge and hold them for exactly one cycle. It also moves gate2 only at falling edges. The mode 2 and mode 3 checks assume counts of at least 2, because 1 is not a valid count in those modes. The random and directed loads therefore stay in the range 2 to 1000.

// File: rtl/triple_interval_timer.sv
module triple_interval_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       wr,
  input  logic       rd,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       gate2,
  output logic [2:0] tmr_out
);

  logic [2:0][2:0]  md;
  logic [2:0][1:0]  acc;
  logic [2:0][15:0] rl, cnt, lat, nv, dn1, dn2;
  logic [2:0][7:0]  lsbh, stat;
  logic [2:0]       bcd, outp, loaded, armed, run, wptr, rptr, latv, statv, done;
  logic             gq;
  logic [15:0]      rsrc;

  function automatic logic [15:0] dec1(input logic [15:0] v, input logic b);
    logic [15:0] r;
    logic go;
    r  = v;
    go = 1'b1;
    if (!b) r = v - 16'd1;
    else
      for (int d = 0; d < 4; d++)
        if (go) begin
          if (r[4*d +: 4] == 4'd0) r[4*d +: 4] = 4'd9;
          else begin
            r[4*d +: 4] = r[4*d +: 4] - 4'd1;
            go = 1'b0;
          end
        end
    return r;
  endfunction

  wire       cmd_wr = cs & wr & (addr == 2'd3);
  wire [1:0] c_ch   = wdata[7:6];
  wire [1:0] c_rw   = wdata[5:4];
  wire [2:0] c_md   = (wdata[3:2] == 2'b11) ? {1'b0, wdata[2:1]} : wdata[3:1];
  wire       rb     = cmd_wr & (wdata[7:4] == 4'b1110);
  wire [2:0] dw     = {cs & wr & (addr == 2'd2), cs & wr & (addr == 2'd1), cs & wr & (addr == 2'd0)};
  wire [2:0] dr     = {cs & rd & (addr == 2'd2), cs & rd & (addr == 2'd1), cs & rd & (addr == 2'd0)};
  wire [2:0] gt     = {gate2, 2'b11};
  wire [2:0] rise   = {gate2 & ~gq, 2'b00};

  assign tmr_out = outp;

  always_comb
    for (int i = 0; i < 3; i++) begin
      dn1[i] = dec1(cnt[i], bcd[i]);
      dn2[i] = dec1(dn1[i], bcd[i]);
      case (acc[i])
        2'b01: begin nv[i] = {8'h00, wdata};   done[i] = dw[i]; end
        2'b10: begin nv[i] = {wdata, 8'h00};   done[i] = dw[i]; end
        default: begin nv[i] = {wdata, lsbh[i]}; done[i] = dw[i] & wptr[i]; end
      endcase
    end

  always_comb begin
    rsrc  = '0;
    rdata = 8'h00;
    if (cs && addr != 2'd3) begin
      if (statv[addr]) rdata = stat[addr];
      else begin
        rsrc = latv[addr] ? lat[addr] : cnt[addr];
        case (acc[addr])
          2'b01:   rdata = rsrc[7:0];
          2'b10:   rdata = rsrc[15:8];
          default: rdata = rptr[addr] ? rsrc[15:8] : rsrc[7:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gq <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        md[i] <= 3'd0; acc[i] <= 2'b11; rl[i] <= '0; cnt[i] <= '0; lat[i] <= '0;
        lsbh[i] <= '0; stat[i] <= '0; bcd[i] <= 1'b0; outp[i] <= 1'b0;
        loaded[i] <= 1'b0; armed[i] <= 1'b0; run[i] <= 1'b0; wptr[i] <= 1'b0;
        rptr[i] <= 1'b0; latv[i] <= 1'b0; statv[i] <= 1'b0;
      end
    end else begin
      gq <= gate2;
      for (int i = 0; i < 3; i++) begin
        if ((md[i] == 3'd4 || md[i] == 3'd5) && !outp[i]) outp[i] <= 1'b1;
        case (md[i])
          3'd0, 3'd4:
            if (run[i] && gt[i]) begin
              cnt[i] <= dn1[i];
              if (dn1[i] == 16'd0) begin
                run[i] <= 1'b0; loaded[i] <= 1'b0; outp[i] <= (md[i] == 3'd0);
              end
            end
          3'd1, 3'd5:
            if (rise[i] && armed[i]) begin
              cnt[i] <= rl[i]; run[i] <= 1'b1; loaded[i] <= 1'b1;
              if (md[i] == 3'd1) outp[i] <= 1'b0;
            end else if (run[i]) begin
              cnt[i] <= dn1[i];
              if (dn1[i] == 16'd0) begin
                run[i] <= 1'b0; loaded[i] <= 1'b0; outp[i] <= (md[i] == 3'd1);
              end
            end
          3'd2:
            if (run[i]) begin
              if (!gt[i]) outp[i] <= 1'b1;
              else if (cnt[i] == 16'd1) begin
                cnt[i] <= rl[i]; outp[i] <= 1'b1;
              end else begin
                cnt[i] <= dn1[i]; outp[i] <= (dn1[i] != 16'd1);
              end
            end
          3'd3:
            if (run[i]) begin
              if (!gt[i]) outp[i] <= 1'b1;
              else if (cnt[i] == ((outp[i] && rl[i][0]) ? 16'd0 : 16'd2)) begin
                outp[i] <= ~outp[i]; cnt[i] <= {rl[i][15:1], 1'b0};
              end else cnt[i] <= dn2[i];
            end
          default: ;
        endcase

        if (cmd_wr && c_ch == 2'(i) && c_rw != 2'b00) begin
          md[i] <= c_md; bcd[i] <= wdata[0]; acc[i] <= c_rw;
          run[i] <= 1'b0; armed[i] <= 1'b0; loaded[i] <= 1'b0;
          outp[i] <= (c_md != 3'd0);
          wptr[i] <= 1'b0; rptr[i] <= 1'b0; latv[i] <= 1'b0; statv[i] <= 1'b0;
        end
        if (cmd_wr && c_ch == 2'(i) && c_rw == 2'b00 && !latv[i]) begin
          lat[i] <= cnt[i]; latv[i] <= 1'b1;
        end
        if (rb && wdata[i+1] && !statv[i]) begin
          stat[i] <= {outp[i], loaded[i], acc[i], md[i], bcd[i]}; statv[i] <= 1'b1;
        end

        if (dw[i]) begin
          if (acc[i] == 2'b11 && !wptr[i]) begin
            lsbh[i] <= wdata; wptr[i] <= 1'b1;
          end else wptr[i] <= 1'b0;
        end
        if (done[i]) begin
          rl[i] <= nv[i]; loaded[i] <= 1'b1; armed[i] <= 1'b1;
          case (md[i])
            3'd0: begin cnt[i] <= nv[i]; run[i] <= 1'b1; outp[i] <= 1'b0; end
            3'd1, 3'd5: begin run[i] <= 1'b0; outp[i] <= 1'b1; end
            3'd3: begin cnt[i] <= {nv[i][15:1], 1'b0}; run[i] <= 1'b1; outp[i] <= 1'b1; end
            default: begin cnt[i] <= nv[i]; run[i] <= 1'b1; outp[i] <= 1'b1; end
          endcase
        end

        if (dr[i]) begin
          if (statv[i]) statv[i] <= 1'b0;
          else if (latv[i]) begin
            if (acc[i] == 2'b11 && !rptr[i]) rptr[i] <= 1'b1;
            else begin rptr[i] <= 1'b0; latv[i] <= 1'b0; end
          end else if (acc[i] == 2'b11) rptr[i] <= ~rptr[i];
        end
      end
    end
  end

endmodule

module triple_interval_timer_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            cs,
  input logic            wr,
  input logic [1:0]      addr,
  input logic [7:1]      cmd,
  input logic            gate2,
  input logic [2:0]      tmr_out,
  input logic [2:0][2:0] md,
  input logic [2:0]      run,
  input logic [1:0]      sq_lsb,
  input logic [15:0]     cnt2,
  input logic            latv0,
  input logic [15:0]     lat0
);

  // R2
  mode0_init_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && cmd[7:6] == 2'd0 && cmd[5:4] != 2'd0 && cmd[3:1] == 3'd0)
    |=> !tmr_out[0]);

  // R7
  sq_even0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md[0] == 3'd3 && run[0]) |-> !sq_lsb[0]);

  // R7
  sq_even1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md[1] == 3'd3 && run[1]) |-> !sq_lsb[1]);

  // R8
  strobe0_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md[0] == 3'd4 && !tmr_out[0] && !(cs && wr)) |=> tmr_out[0]);

  // R8
  strobe1_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md[1] == 3'd4 && !tmr_out[1] && !(cs && wr)) |=> tmr_out[1]);

  // R10
  gate_rate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md[2] == 3'd2 && run[2] && !gate2 && !(cs && wr)) |=> tmr_out[2]);

  // R10
  gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md[2] == 3'd0 && run[2] && !gate2 && !(cs && wr)) |=> $stable(cnt2));

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latv0 |=> (!latv0 || $stable(lat0)));

endmodule

bind triple_interval_timer triple_interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .cmd(wdata[7:1]),
  .gate2(gate2), .tmr_out(tmr_out), .md(md), .run(run),
  .sq_lsb({cnt[1][0], cnt[0][0]}), .cnt2(cnt[2]), .latv0(latv[0]), .lat0(lat[0])
);

// File: tb/triple_interval_timer_tb.sv
module triple_interval_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, gate2 = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] tmr_out;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  triple_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gate2(gate2), .tmr_out(tmr_out)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic load16(input logic [1:0] ch, input logic [15:0] n);
    bus_wr(ch, n[7:0]);
    bus_wr(ch, n[15:8]);
  endtask

  task automatic read16(input logic [1:0] ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_rd(ch, lo);
    bus_rd(ch, hi);
    v = {hi, lo};
  endtask

  function automatic logic exp_out(input int mode, input int n, input int j);
    case (mode)
      0, 1: return j >= n;
      2:    return (j % n) != n - 1;
      3:    return (j % n) < (n + 1) / 2;
      default: return j != n;
    endcase
  endfunction

  task automatic wave(input int ch, input int mode, input int n, input int cycles, input string req);
    check(req, tmr_out[ch], exp_out(mode, n, 0));
    for (int j = 1; j <= cycles; j++) begin
      @(negedge clk);
      check(req, tmr_out[ch], exp_out(mode, n, j));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, va;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 outputs", tmr_out, 3'b000);
    bus_wr(3, 8'hE2); bus_rd(0, b);
    check("R1 status ch0", b, 8'h30);

    bus_wr(3, 8'h30);
    check("R2 mode0 start low", tmr_out[0], 1'b0);
    load16(0, 16'd17);
    wave(0, 0, 17, 20, "R4");
    bus_wr(3, 8'h30);
    check("R2 mode write resets output", tmr_out[0], 1'b0);

    bus_wr(3, 8'h78); load16(1, 16'd9);
    wave(1, 4, 9, 12, "R8");

    bus_wr(3, 8'h34); load16(0, 16'd5);
    wave(0, 2, 5, 16, "R6");

    bus_wr(3, 8'h76); load16(1, 16'd7);
    wave(1, 3, 7, 22, "R7 odd");
    bus_wr(3, 8'h76); load16(1, 16'd6);
    wave(1, 3, 6, 20, "R7 even");
    bus_wr(3, 8'h76); load16(1, 16'd301);
    for (int k = 0; k < 4; k++) begin
      repeat (k + 1) @(negedge clk);
      bus_wr(3, 8'h40); read16(1, v);
      check("R7 even readback", v[0], 1'b0);
    end

    bus_wr(3, 8'h7C); bus_wr(3, 8'hE4); bus_rd(1, b);
    check("R2 mode 110 alias", b, 8'hB4);

    bus_wr(3, 8'h70); bus_wr(1, 8'h05);
    repeat (5) @(negedge clk);
    check("R3 half written", tmr_out[1], 1'b0);
    bus_wr(3, 8'hE4); bus_rd(1, b);
    check("R3 not loaded status", b, 8'h30);
    bus_wr(1, 8'h00);
    wave(1, 0, 5, 7, "R3 start after final byte");

    bus_wr(3, 8'h54); bus_wr(1, 8'h05);
    wave(1, 2, 5, 12, "R14 low byte only");
    bus_wr(3, 8'h20); bus_wr(0, 8'h01);
    repeat (255) @(negedge clk);
    check("R14 high byte only pre", tmr_out[0], 1'b0);
    @(negedge clk);
    check("R14 high byte only", tmr_out[0], 1'b1);
    bus_wr(3, 8'hE2); bus_rd(0, b);
    check("R12 expired status", b, 8'hA0);

    bus_wr(3, 8'h31); load16(0, 16'h0100);
    @(negedge clk);
    bus_wr(3, 8'h00); read16(0, v);
    check("R13 bcd step", v, 16'h0099);
    bus_wr(3, 8'h31); load16(0, 16'h0012);
    wave(0, 0, 12, 14, "R13 bcd timeout");

    bus_wr(3, 8'h34); load16(0, 16'd1000);
    bus_wr(3, 8'h00);
    repeat (5) @(negedge clk);
    bus_wr(3, 8'h00);
    read16(0, v);
    check("R11 first latch kept", v, 16'd1000);
    bus_wr(3, 8'h00); read16(0, v);
    check("R11 relatch after read", v, 16'd991);

    gate2 = 1'b0;
    bus_wr(3, 8'hB2); load16(2, 16'd6);
    repeat (3) @(negedge clk);
    check("R5 waits for trigger", tmr_out[2], 1'b1);
    bus_wr(3, 8'hE8);
    gate2 = 1'b1;
    @(negedge clk);
    check("R5 trigger", tmr_out[2], 1'b0);
    for (int j = 1; j <= 8; j++) begin
      if (j == 2) gate2 = 1'b0;
      @(negedge clk);
      check("R5", tmr_out[2], exp_out(1, 6, j));
    end
    bus_wr(3, 8'hE8); bus_rd(2, b);
    check("R12 pending status kept", b, 8'hF2);

    gate2 = 1'b0;
    bus_wr(3, 8'hBA); load16(2, 16'd4);
    @(negedge clk);
    gate2 = 1'b1;
    @(negedge clk);
    wave(2, 5, 4, 6, "R9");

    gate2 = 1'b0;
    bus_wr(3, 8'hB0); load16(2, 16'd10);
    repeat (12) @(negedge clk);
    check("R10 gate low mode0 out", tmr_out[2], 1'b0);
    bus_wr(3, 8'h80); read16(2, v);
    check("R10 gate low mode0 count", v, 16'd10);
    gate2 = 1'b1;
    for (int j = 1; j <= 11; j++) begin
      @(negedge clk);
      check("R10 resume", tmr_out[2], exp_out(0, 10, j));
    end

    bus_wr(3, 8'hB4); load16(2, 16'd8);
    repeat (3) @(negedge clk);
    gate2 = 1'b0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      check("R10 mode2 held high", tmr_out[2], 1'b1);
    end
    bus_wr(3, 8'h80); read16(2, va);
    repeat (4) @(negedge clk);
    bus_wr(3, 8'h80); read16(2, v);
    check("R10 mode2 frozen", v, va);
    gate2 = 1'b1;

    for (int it = 0; it < 16; it++) begin
      int ch, mode, n;
      int modes[4] = '{0, 2, 3, 4};
      ch   = int'($urandom % 2);
      mode = modes[$urandom % 4];
      n    = 2 + int'($urandom % 40);
      bus_wr(3, {ch[1:0], 2'b11, mode[2:0], 1'b0});
      load16(ch[1:0], n[15:0]);
      case (mode)
        0: wave(ch, mode, n, 2 * n + 3, "R4 random");
        2: wave(ch, mode, n, 2 * n + 3, "R6 random");
        3: wave(ch, mode, n, 2 * n + 3, "R7 random");
        default: wave(ch, mode, n, 2 * n + 3, "R8 random");
      endcase
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule